// File: doc/BRIEF.md
# Per-Bank DRAM Refresh Sequencer with Shared Activate Window

This block schedules single-bank refreshes for an eight-bank low-power DRAM. A refresh-due tick from a timer adds to a count of owed refreshes. The sequencer then refreshes the banks one at a time, in rotating order. Only the bank being refreshed is reported as blocked, for a fixed number of cycles. The other banks stay free for the main command scheduler. A per-bank refresh is far from one eighth of an all-bank refresh in cost. Its main value is that it lets traffic to the remaining banks keep flowing.

Activates and per-bank refreshes draw on the same rolling four-issue window. The block tracks the last four issue times, whatever their source. A new activate or refresh may only start once the oldest of those four is at least a window length old. When the main scheduler requests an activate in a cycle where a refresh could also start, the activate is granted. The one exception is a full refresh debt, in which case the refresh goes first. All outputs are registered, so every decision appears on the outputs one cycle after the inputs that caused it.

Top module: `pb_refresh_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `ref_cmd`, `act_grant` and `bank_blocked` are all zero, and `ref_bank` is 0. The owed count is zero, the target bank is 0 and the window is empty.
- R2: Each cycle with `refresh_tick` high adds one owed refresh, up to a cap of `DEBT_MAX` (default 8). A tick with the count at the cap is lost, so that number of ticks followed by more ticks yields exactly `DEBT_MAX` refreshes.
- R3: A refresh is decided in a cycle only if four conditions all hold: the owed count is nonzero, no refresh is in progress, the target bank's `bank_idle` bit is 1 and the window has room. `ref_cmd` is then high for exactly the next cycle.
- R4: Refreshes target banks 0, 1, ... `NUM_BANKS`-1 and then 0 again. `ref_bank` carries the bank index in the cycle `ref_cmd` is high and holds it afterwards.
- R5: `bank_blocked` has bit b set for exactly `RFPB_CYC` cycles (default 5), starting with the cycle in which `ref_cmd` reports bank b. At all other times it is zero, and it never has more than one bit set.
- R6: An activate request is granted (`act_grant` high in the following cycle) when the window has room and no refresh wins the cycle. Counting both sources, at most four issues fall in any `FAW_CYC` consecutive decision cycles (default 10).
- R7: When an activate request and an eligible refresh meet in one cycle, the activate wins. The refresh wins only if the owed count equals `DEBT_MAX`. The two are never issued together.
- R8: If the target bank's idle bit is 0, refresh waits. It does not skip to another bank, and it resumes on that same bank once the bit returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_idle | input | NUM_BANKS | Bit b is 1 when bank b may be refreshed |
| act_req | input | 1 | The main scheduler wants to issue an activate this cycle |
| refresh_tick | input | 1 | One per-bank refresh becomes due |
| ref_cmd | output | 1 | One-cycle per-bank refresh command |
| ref_bank | output | clog2(NUM_BANKS) | Bank index of the refresh command |
| bank_blocked | output | NUM_BANKS | One-hot bank under refresh, zero when none |
| act_grant | output | 1 | The activate requested in the previous cycle may issue |

## Verification
The hardest situation to reach is a full owed count meeting a live activate request while the window has room. This is the only case where a refresh overtakes the scheduler. The stimulus holds every idle bit low while it fires enough ticks to fill the owed count. It then raises the activate request and the idle bits in the same cycle. The bench also holds a single target bank non-idle to show that the rotation stalls rather than skips. A long random mix of requests, ticks and idle patterns then keeps the window saturated from both sources.

// File: rtl/refseq_pkg.sv
package refseq_pkg;
  typedef enum logic [1:0] {
    ISSUE_NONE = 2'd0,
    ISSUE_ACT  = 2'd1,
    ISSUE_REF  = 2'd2
  } issue_e;
endpackage

// File: rtl/refseq_faw_window.sv
module refseq_faw_window #(
  parameter int SLOTS   = 4,
  parameter int FAW_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  output logic room
);
  localparam int AW = $clog2(FAW_CYC + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(FAW_CYC);

  logic [AW-1:0] age_q [SLOTS];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return (a >= AGE_MAX) ? AGE_MAX : a + 1'b1;
  endfunction

  // Ages of the last SLOTS issues, newest in slot 0, saturating at the window
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        age_q[i] <= AGE_MAX;
      end else if (issue) begin
        if (i == 0) age_q[i] <= AW'(1);
        else        age_q[i] <= bump(age_q[i-1]);
      end else begin
        age_q[i] <= bump(age_q[i]);
      end
    end
  end

  assign room = (age_q[SLOTS-1] >= AGE_MAX);

  // R6: nothing is issued while the window is full
  a_r6_issue_has_room: assert property (@(posedge clk) disable iff (rst)
    issue |-> room);
endmodule

// File: rtl/refseq_debt_ctr.sv
module refseq_debt_ctr #(
  parameter int DEBT_MAX = 8,
  localparam int DW = $clog2(DEBT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          take,
  output logic [DW-1:0] owed,
  output logic          full
);
  logic [DW-1:0] owed_q, owed_d;

  always_comb begin
    owed_d = owed_q - DW'(take);
    if (tick && owed_d != DW'(DEBT_MAX)) owed_d = owed_d + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) owed_q <= '0;
    else     owed_q <= owed_d;
  end

  assign owed = owed_q;
  assign full = (owed_q == DW'(DEBT_MAX));

  // R2: the count stays within its cap
  a_r2_debt_bounded: assert property (@(posedge clk) disable iff (rst)
    owed_q <= DW'(DEBT_MAX));
  // R3: a refresh is only taken against an owed one
  a_r3_take_needs_debt: assert property (@(posedge clk) disable iff (rst)
    take |-> owed_q != '0);
endmodule

// File: rtl/refseq_bank_track.sv
module refseq_bank_track #(
  parameter int NUM_BANKS = 8,
  parameter int RFPB_CYC  = 5,
  localparam int BW = $clog2(NUM_BANKS),
  localparam int CW = $clog2(RFPB_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [NUM_BANKS-1:0] bank_idle,
  output logic [BW-1:0]        target,
  output logic                 can_start,
  output logic [NUM_BANKS-1:0] blocked
);
  logic [BW-1:0]        ptr_q;
  logic [CW-1:0]        cnt_q;
  logic [NUM_BANKS-1:0] blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
      blk_q <= '0;
    end else if (start) begin
      blk_q <= NUM_BANKS'(1) << ptr_q;
      cnt_q <= CW'(RFPB_CYC);
      ptr_q <= (ptr_q == BW'(NUM_BANKS - 1)) ? '0 : ptr_q + 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) blk_q <= '0;
    end
  end

  assign target    = ptr_q;
  assign can_start = (cnt_q == '0) && bank_idle[ptr_q];
  assign blocked   = blk_q;

  // R5: at most one bank is blocked
  a_r5_blocked_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(blk_q));
  // R8: a refresh only starts on an idle target
  a_r8_start_on_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> bank_idle[ptr_q]);
endmodule

// File: rtl/pb_refresh_seq.sv
module pb_refresh_seq
  import refseq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int RFPB_CYC  = 5,
  parameter int FAW_CYC   = 10,
  parameter int FAW_SLOTS = 4,
  parameter int DEBT_MAX  = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] bank_idle,
  input  logic                 act_req,
  input  logic                 refresh_tick,
  output logic                 ref_cmd,
  output logic [BANK_W-1:0]    ref_bank,
  output logic [NUM_BANKS-1:0] bank_blocked,
  output logic                 act_grant
);
  localparam int DW = $clog2(DEBT_MAX + 1);

  logic              room, can_start, debt_full, ref_ok, act_ok;
  logic [DW-1:0]     owed;
  logic [BANK_W-1:0] target;
  issue_e            sel;

  refseq_faw_window #(.SLOTS(FAW_SLOTS), .FAW_CYC(FAW_CYC)) u_win (
    .clk(clk), .rst(rst), .issue(sel != ISSUE_NONE), .room(room));

  refseq_debt_ctr #(.DEBT_MAX(DEBT_MAX)) u_debt (
    .clk(clk), .rst(rst), .tick(refresh_tick), .take(sel == ISSUE_REF),
    .owed(owed), .full(debt_full));

  refseq_bank_track #(.NUM_BANKS(NUM_BANKS), .RFPB_CYC(RFPB_CYC)) u_trk (
    .clk(clk), .rst(rst), .start(sel == ISSUE_REF), .bank_idle(bank_idle),
    .target(target), .can_start(can_start), .blocked(bank_blocked));

  // Arbitration: the scheduler's activate first unless the debt is at its cap
  always_comb begin
    ref_ok = (owed != '0) && can_start && room;
    act_ok = act_req && room;
    if (ref_ok && (!act_ok || debt_full)) sel = ISSUE_REF;
    else if (act_ok)                      sel = ISSUE_ACT;
    else                                  sel = ISSUE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cmd   <= 1'b0;
      ref_bank  <= '0;
      act_grant <= 1'b0;
    end else begin
      ref_cmd   <= (sel == ISSUE_REF);
      act_grant <= (sel == ISSUE_ACT);
      if (sel == ISSUE_REF) ref_bank <= target;
    end
  end

  // R1: outputs are quiet right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ref_cmd && !act_grant && bank_blocked == '0));
  // R7: refresh and activate never issue together
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ref_cmd && act_grant));
  // R3: the refresh command is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |=> !ref_cmd);
  // R5: the reported bank is the one blocked
  a_r5_blocked_matches: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |-> bank_blocked == (NUM_BANKS'(1) << ref_bank));
endmodule

// File: tb/pb_refresh_seq_tb.sv
module pb_refresh_seq_tb_top;
  localparam int NB = 8, RFPB = 5, FAW = 10, SLOTS = 4, DMAX = 8;

  logic clk = 1'b0;
  logic rst;
  logic [NB-1:0] idle;
  logic act_req, tick;
  logic ref_cmd, act_grant;
  logic [2:0] ref_bank;
  logic [NB-1:0] blocked;

  always #10 clk = ~clk;

  pb_refresh_seq #(.NUM_BANKS(NB), .RFPB_CYC(RFPB), .FAW_CYC(FAW),
    .FAW_SLOTS(SLOTS), .DEBT_MAX(DMAX)) dut_i (
    .clk(clk), .rst(rst), .bank_idle(idle), .act_req(act_req),
    .refresh_tick(tick), .ref_cmd(ref_cmd), .ref_bank(ref_bank),
    .bank_blocked(blocked), .act_grant(act_grant));

  int n_cmp = 0, n_bad = 0, ref_seen = 0;
  bit done = 0;

  // Behavioural reference model
  int debt, ptr, busy_left, blk_bank, cyc;
  int hist[$];
  bit e_ref, e_act;
  int e_bank;
  string tag_ref;
  bit in_rst;

  always @(posedge clk) begin
    bit room, rel, ael, do_ref, do_act;
    if (rst) begin
      debt = 0; ptr = 0; busy_left = 0; blk_bank = 0; cyc = 0;
      hist.delete(); e_ref = 0; e_act = 0; e_bank = 0; in_rst = 1;
      tag_ref = "R1";
    end else begin
      in_rst = 0;
      room = (hist.size() < SLOTS) || ((cyc - hist[hist.size()-SLOTS]) >= FAW);
      rel = (debt > 0) && (busy_left == 0) && idle[ptr] && room;
      ael = act_req && room;
      do_ref = rel && (!ael || debt == DMAX);
      do_act = ael && !do_ref;
      if (ael && rel) tag_ref = "R7";
      else if (debt > 0 && busy_left == 0 && !idle[ptr]) tag_ref = "R8";
      else tag_ref = "R3";
      e_ref = do_ref; e_act = do_act;
      if (do_ref) begin
        e_bank = ptr; blk_bank = ptr; busy_left = RFPB;
        ptr = (ptr + 1) % NB;
        debt = debt - 1;
      end else if (busy_left > 0) busy_left = busy_left - 1;
      if (tick && debt < DMAX) debt = debt + 1;
      if (do_ref || do_act) begin
        hist.push_back(cyc);
        if (hist.size() > SLOTS) void'(hist.pop_front());
      end
      cyc = cyc + 1;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int e_blk;
    e_blk = (busy_left > 0) ? (1 << blk_bank) : 0;
    if (in_rst) begin
      chk("R1", "ref_cmd", ref_cmd, 0);
      chk("R1", "act_grant", act_grant, 0);
      chk("R1", "bank_blocked", blocked, 0);
      chk("R1", "ref_bank", ref_bank, 0);
    end else begin
      chk(tag_ref, "ref_cmd", ref_cmd, e_ref);
      chk("R4", "ref_bank", ref_bank, e_bank);
      chk("R5", "bank_blocked", blocked, e_blk);
      chk("R6", "act_grant", act_grant, e_act);
    end
    if (ref_cmd) ref_seen++;
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c0;
    rst = 1; idle = '1; act_req = 0; tick = 0;
    cycles(4);
    rst = 0;
    // R3/R4/R5: three ticks, all banks idle
    repeat (3) begin tick = 1; cycles(1); tick = 0; cycles(1); end
    cycles(30);
    // R8: target bank 3 held busy, no refresh may start
    idle = ~8'b0000_1000;
    tick = 1; cycles(1); tick = 0;
    @(negedge clk); #1 c0 = ref_seen;
    cycles(20);
    #1 chk("R8", "refreshes while target busy", ref_seen - c0, 0);
    idle = '1;
    cycles(12);
    // R6: activate stream with ticks mixed in
    act_req = 1;
    for (int i = 0; i < 40; i++) begin tick = (i % 7 == 0); cycles(1); end
    tick = 0; act_req = 0;
    cycles(40);
    // R2: twelve ticks with every bank busy, then release
    idle = '0;
    repeat (12) begin tick = 1; cycles(1); end
    tick = 0; cycles(3);
    @(negedge clk); #1 c0 = ref_seen;
    idle = '1;
    cycles(90);
    #1 chk("R2", "refreshes after saturated ticks", ref_seen - c0, DMAX);
    // R7: full debt meets an activate request
    idle = '0;
    repeat (DMAX) begin tick = 1; cycles(1); end
    tick = 0; cycles(FAW + 2);
    idle = '1; act_req = 1;
    cycles(60);
    act_req = 0; cycles(30);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      idle = NB'($urandom) | NB'($urandom);
      act_req = ($urandom % 2) == 0;
      tick = ($urandom % 10) == 0;
      cycles(1);
    end
    idle = '1; act_req = 0; tick = 0;
    cycles(120);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule